// File: doc/BRIEF.md
# Stereo PCM Serial Transmitter

This block turns parallel stereo samples into a three-wire serial audio stream made of a bit clock, a word clock and a data line. A left/right pair captured at one sampling instant enters through a valid/ready port. The pair is held until a left half-frame begins. The two channels then go out one after the other, each 24-bit two's-complement word most significant bit first. Slots that follow the last data bit carry zeros.

Two static pins set how the block works. The format pin chooses between I2S framing and left-justified framing. The clock-role pin chooses between two modes. In master mode the block divides its own clock by 4 for the bit clock and by 256 for the word clock, and drives both. In slave mode it follows an external bit clock and word clock. It samples them through a synchronizer, so the system clock must run at least 8 times faster than the external bit clock. Both pins may change only while reset is asserted.

The input port takes back-pressure in this way. `s_ready` is high whenever no pair is waiting. A pair moves across on a clock edge where `s_valid` and `s_ready` are both high. It then stays in the holding stage until the next left half-frame starts, and `s_ready` stays low for that whole time. If no pair is waiting when a frame starts, that frame carries silence (zeros).

Top module: `pcm_serial_tx`

## Requirements
- R1: Each channel word is 24 bits, two's complement, sent most significant bit first in consecutive bit slots.
- R2: With `fmt_i2s` high, the word clock is low for the left channel and high for the right, and the MSB sits in the second bit slot after each word-clock change.
- R3: With `fmt_i2s` low, the word clock is high for the left channel and low for the right, and the MSB sits in the first bit slot after each word-clock change.
- R4: With `slave_mode` low, `clk_oe` is high, `bclk_o` has a period of 4 clocks, each half-frame has 32 bit slots, and `wclk_o` has a period of 256 clocks.
- R5: In master mode, `wclk_o` changes only in the cycle where `bclk_o` falls, and `sdata` changes only in the cycle after `bclk_o` falls, so a receiver can sample on the rising bit-clock edge.
- R6: With `slave_mode` high, `clk_oe` is low, and the block follows `bclk_in`/`wclk_in` for any count from 24 to 64 bit slots per half-frame (48 to 128 per frame), provided the system clock is at least 8 times the bit-clock rate.
- R7: Every slot after a word's 24th bit reads zero up to the next word-clock change. When a half-frame has too few slots, the lowest-order bits that do not fit are dropped.
- R8: A pair is taken from the holding stage only at the start of a left half-frame, so left and right in one frame always come from the same input pair. A frame that starts with the holding stage empty sends zeros on both channels.
- R9: If a pair is accepted on the same clock edge on which a left half-frame takes its data, the pair is not used for that frame. That frame sends zeros, and the pair goes out in the next frame.
- R10: While `rst_n` is low, `sdata` is low at once (asynchronous reset). After reset, `s_ready` is high and `sdata` stays low until the first left half-frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; master-mode clocks are divided from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i2s | input | 1 | 1 = I2S framing, 0 = left-justified framing |
| slave_mode | input | 1 | 1 = follow external clocks, 0 = generate clocks |
| s_valid | input | 1 | Sample pair on `s_left`/`s_right` is valid |
| s_ready | output | 1 | Holding stage empty; pair accepted when `s_valid` is also high |
| s_left | input | 24 | Left-channel sample, two's complement |
| s_right | input | 24 | Right-channel sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave mode) |
| wclk_in | input | 1 | External word clock (slave mode) |
| bclk_o | output | 1 | Generated bit clock (master mode, else low) |
| wclk_o | output | 1 | Generated word clock (master mode, else low) |
| clk_oe | output | 1 | High when the block drives the bit and word clocks |
| sdata | output | 1 | Serial audio data |

## Verification
The case that needs care is a pair handshake that lands on the same edge as the frame-start load, where the holding stage is filled and read at once. The bench watches `wclk_o` until it sees the change into the second left half-frame after reset. It then raises `s_valid` in the same cycle, so the acceptance edge and the load edge coincide. It judges the result from the decoded stream: that frame must carry zeros on both channels and the next frame must carry the pair. It also checks that `s_ready` is low right after that edge.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int unsigned SAMPLE_W = 24;
  localparam int unsigned SEL_W    = $clog2(SAMPLE_W);

  typedef logic [SAMPLE_W-1:0] sample_t;

  typedef struct packed {
    sample_t left;
    sample_t right;
  } pair_t;
endpackage

// File: rtl/pcm_clk_master.sv
module pcm_clk_master #(
  parameter int unsigned DIV_LOG2   = 2,
  parameter int unsigned FRAME_LOG2 = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic bclk,
  output logic phase_right
);
  localparam int unsigned HALF_BIT = 2 ** (DIV_LOG2 - 1);
  // start in the last bit slot of a right half, bit clock high
  localparam logic [FRAME_LOG2-1:0] RST_CNT =
    {FRAME_LOG2{1'b1}} - FRAME_LOG2'(HALF_BIT - 1);

  logic [FRAME_LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= RST_CNT;
    else        cnt <= cnt + 1'b1;
  end

  assign bclk        = cnt[DIV_LOG2-1];
  assign phase_right = cnt[FRAME_LOG2-1];
endmodule

// File: rtl/pcm_clk_sync.sv
module pcm_clk_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= '0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/pcm_pair_buffer.sv
module pcm_pair_buffer
  import pcm_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  pair_t in_pair,
  input  logic  pop,
  output logic  full,
  output pair_t out_pair
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_pair <= '0;
    end else if (in_valid && !full) begin
      full     <= 1'b1;
      out_pair <= in_pair;
    end else if (pop) begin
      full     <= 1'b0;
    end
  end

  assign in_ready = ~full;
endmodule

// File: rtl/pcm_word_shifter.sv
module pcm_word_shifter
  import pcm_tx_pkg::*;
#(
  parameter int unsigned POS_W = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bclk_lvl,
  input  logic  chan_right,
  input  logic  fmt_i2s,
  input  logic  buf_full,
  input  pair_t buf_pair,
  output logic  pop,
  output logic  sdata
);
  localparam int unsigned IDX_W = POS_W + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             prev_b;
  logic             chan_prev;
  logic             locked;
  logic [POS_W-1:0] pos;
  pair_t            cur;

  logic             fall;
  logic             change;
  logic             start_left;
  logic             locked_n;
  logic [POS_W-1:0] pos_n;
  pair_t            cur_n;
  sample_t          word;
  logic [IDX_W-1:0] idx;
  logic             bit_n;

  always_comb begin
    fall       = prev_b & ~bclk_lvl;
    change     = chan_right != chan_prev;
    start_left = fall & change & ~chan_right;
    locked_n   = locked | start_left;
    if (change)              pos_n = '0;
    else if (pos == POS_MAX) pos_n = pos;
    else                     pos_n = pos + 1'b1;
    pop   = start_left & buf_full;
    if (start_left) cur_n = buf_full ? buf_pair : '0;
    else            cur_n = cur;
    word  = chan_right ? cur_n.right : cur_n.left;
    // slot index minus framing delay; wraps high for the I2S lead slot
    idx   = {1'b0, pos_n} - IDX_W'(fmt_i2s);
    if (idx < IDX_W'(SAMPLE_W))
      bit_n = word[SEL_W'(SAMPLE_W - 1) - idx[SEL_W-1:0]];
    else
      bit_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_b    <= 1'b0;
      chan_prev <= 1'b1;
      locked    <= 1'b0;
      pos       <= POS_MAX;
      cur       <= '0;
      sdata     <= 1'b0;
    end else begin
      prev_b <= bclk_lvl;
      if (fall) begin
        chan_prev <= chan_right;
        locked    <= locked_n;
        pos       <= pos_n;
        cur       <= cur_n;
        sdata     <= locked_n & bit_n;
      end
    end
  end
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import pcm_tx_pkg::*;
#(
  parameter int unsigned DIV_LOG2    = 2,
  parameter int unsigned FRAME_LOG2  = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POS_W       = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_i2s,
  input  logic                slave_mode,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_left,
  input  logic [SAMPLE_W-1:0] s_right,
  input  logic                bclk_in,
  input  logic                wclk_in,
  output logic                bclk_o,
  output logic                wclk_o,
  output logic                clk_oe,
  output logic                sdata
);
  logic       m_bclk;
  logic       m_right;
  logic [1:0] ext_sync;
  logic       bclk_lvl;
  logic       chan_right;
  logic       buf_full;
  logic       pop;
  pair_t      buf_pair;
  pair_t      in_pair;

  pcm_clk_master #(
    .DIV_LOG2  (DIV_LOG2),
    .FRAME_LOG2(FRAME_LOG2)
  ) u_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk       (m_bclk),
    .phase_right(m_right)
  );

  pcm_clk_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (2)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({wclk_in, bclk_in}),
    .q    (ext_sync)
  );

  always_comb begin
    if (slave_mode) begin
      bclk_lvl   = ext_sync[0];
      chan_right = fmt_i2s ? ext_sync[1] : ~ext_sync[1];
    end else begin
      bclk_lvl   = m_bclk;
      chan_right = m_right;
    end
  end

  assign clk_oe = ~slave_mode;
  assign bclk_o = ~slave_mode & m_bclk;
  assign wclk_o = ~slave_mode & (fmt_i2s ? m_right : ~m_right);

  assign in_pair = '{left: s_left, right: s_right};

  pcm_pair_buffer u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(s_valid),
    .in_ready(s_ready),
    .in_pair (in_pair),
    .pop     (pop),
    .full    (buf_full),
    .out_pair(buf_pair)
  );

  pcm_word_shifter #(
    .POS_W(POS_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_lvl  (bclk_lvl),
    .chan_right(chan_right),
    .fmt_i2s   (fmt_i2s),
    .buf_full  (buf_full),
    .buf_pair  (buf_pair),
    .pop       (pop),
    .sdata     (sdata)
  );
endmodule

// File: rtl/pcm_serial_tx_chk.sv
module pcm_serial_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic fmt_i2s,
  input logic slave_mode,
  input logic s_valid,
  input logic s_ready,
  input logic bclk_o,
  input logic wclk_o,
  input logic sdata
);
  logic [1:0] past_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              past_cnt <= 2'd0;
    else if (past_cnt != 2'd2) past_cnt <= past_cnt + 2'd1;
  end

  // R5
  wclk_on_bfall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_cnt != 2'd0 && !slave_mode && wclk_o != $past(wclk_o))
      |-> (!bclk_o && $past(bclk_o)));

  // R5
  sdata_after_bfall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_cnt == 2'd2 && !slave_mode && sdata != $past(sdata))
      |-> (!$past(bclk_o) && $past(bclk_o, 2)));

  // R8
  load_at_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_cnt == 2'd2 && !slave_mode && s_ready && !$past(s_ready))
      |-> ($past(wclk_o) == !fmt_i2s && $past(wclk_o, 2) == fmt_i2s && !$past(bclk_o)));

  // R8
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (past_cnt != 2'd0 && !s_ready && $past(s_ready)) |-> $past(s_valid));

  // R10
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_quiet_chk: assert (sdata == 1'b0);
    end
  end
endmodule

bind pcm_serial_tx pcm_serial_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_i2s   (fmt_i2s),
  .slave_mode(slave_mode),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .bclk_o    (bclk_o),
  .wclk_o    (wclk_o),
  .sdata     (sdata)
);

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;
  import pcm_tx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;
  localparam pair_t VEC [NVEC] = '{
    '{left: 24'h800000, right: 24'h7FFFFF},
    '{left: 24'h123456, right: 24'hFEDCBA},
    '{left: 24'hA5A5A5, right: 24'h5A5A5A},
    '{left: 24'h000001, right: 24'h800001},
    '{left: 24'hFFFFFF, right: 24'h000000},
    '{left: 24'h7F00FF, right: 24'h00FF80}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fmt_i2s = 1'b0;
  logic slave_mode = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [SAMPLE_W-1:0] s_left = '0;
  logic [SAMPLE_W-1:0] s_right = '0;
  logic tb_bclk = 1'b1;
  logic tb_wclk = 1'b0;
  logic bclk_o, wclk_o, clk_oe, sdata;

  int n_checks = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_serial_tx u0 (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .slave_mode(slave_mode),
    .s_valid(s_valid), .s_ready(s_ready), .s_left(s_left), .s_right(s_right),
    .bclk_in(tb_bclk), .wclk_in(tb_wclk),
    .bclk_o(bclk_o), .wclk_o(wclk_o), .clk_oe(clk_oe), .sdata(sdata)
  );

  wire bus_bclk = slave_mode ? tb_bclk : bclk_o;
  wire bus_wclk = slave_mode ? tb_wclk : wclk_o;

  // receiver model: decodes the stream on rising bit-clock edges
  sample_t rx_l [16];
  sample_t rx_r [16];
  int      rx_n, rx_slot, rx_pad_err, rx_smin, rx_smax;
  logic    rx_ch, rx_seen, rx_have_l;
  sample_t rx_word, rx_lw;

  task automatic rx_clear();
    rx_n = 0; rx_slot = 0; rx_pad_err = 0; rx_smin = 1000; rx_smax = 0;
    rx_ch = 1'b1; rx_seen = 1'b0; rx_have_l = 1'b0; rx_word = '0; rx_lw = '0;
  endtask

  always @(posedge bus_bclk) begin
    logic rch;
    int   idx;
    rch = fmt_i2s ? bus_wclk : ~bus_wclk;
    if (rch != rx_ch) begin
      if (rx_seen) begin
        if (rx_slot + 1 < rx_smin) rx_smin = rx_slot + 1;
        if (rx_slot + 1 > rx_smax) rx_smax = rx_slot + 1;
        if (!rx_ch) begin
          rx_lw = rx_word; rx_have_l = 1'b1;
        end else if (rx_have_l && rx_n < 16) begin
          rx_l[rx_n] = rx_lw; rx_r[rx_n] = rx_word; rx_n++; rx_have_l = 1'b0;
        end
      end
      if (!rch) rx_seen = 1'b1;
      rx_slot = 0;
      rx_word = '0;
    end else begin
      rx_slot++;
    end
    rx_ch = rch;
    idx = rx_slot - (fmt_i2s ? 1 : 0);
    if (rx_seen) begin
      if (idx >= 0 && idx < SAMPLE_W) rx_word[SAMPLE_W-1-idx] = sdata;
      else if (sdata) rx_pad_err++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [47:0] act, input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic fmt, input logic slv);
    rst_n = 1'b0;
    s_valid = 1'b0;
    fmt_i2s = fmt;
    slave_mode = slv;
    tb_bclk = 1'b1;
    tb_wclk = fmt;          // right-channel level for the chosen framing
    repeat (3) @(posedge clk);
    rx_clear();
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input pair_t p);
    @(negedge clk);
    s_valid = 1'b1; s_left = p.left; s_right = p.right;
    while (!s_ready) @(negedge clk);
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic period_of(input bit use_w, output int n);
    logic prev, cur;
    int seen;
    seen = 0; n = 0;
    @(posedge clk); #1; prev = use_w ? wclk_o : bclk_o;
    while (seen < 2) begin
      @(posedge clk); #1;
      cur = use_w ? wclk_o : bclk_o;
      if (seen == 1) n++;
      if (cur && !prev) seen++;
      prev = cur;
    end
  endtask

  task automatic sbit(input logic wl);
    @(posedge clk); #2;
    tb_bclk = 1'b0; tb_wclk = wl;
    repeat (4) @(posedge clk); #2;
    tb_bclk = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic gen_frames(input int half, input int frames, input logic fmt);
    for (int i = 0; i < 2; i++) sbit(fmt);
    for (int f = 0; f < frames; f++) begin
      for (int i = 0; i < half; i++) sbit(~fmt);
      for (int i = 0; i < half; i++) sbit(fmt);
    end
    for (int i = 0; i < 2; i++) sbit(~fmt);
  endtask

  task automatic master_run(input logic fmt, input string req);
    int per;
    do_reset(fmt, 1'b0);
    for (int k = 0; k < NVEC; k++) push(VEC[k]);
    wait (rx_n >= NVEC);
    for (int k = 0; k < NVEC; k++)
      check(rx_l[k] == VEC[k].left && rx_r[k] == VEC[k].right, req, "R1 pair word",
            {rx_l[k], rx_r[k]}, {VEC[k].left, VEC[k].right});
    check(rx_pad_err == 0, "R7", "nonzero pad slots", 48'(rx_pad_err), 48'd0);
    check(rx_smin == 32 && rx_smax == 32, "R4", "slots per half",
          48'(rx_smin), 48'd32);
    period_of(1'b0, per);
    check(per == 4, "R4", "bclk period", 48'(per), 48'd4);
    period_of(1'b1, per);
    check(per == 256, "R4", "wclk period", 48'(per), 48'd256);
  endtask

  task automatic slave_run(input logic fmt, input int half);
    int cap;
    sample_t mask;
    do_reset(fmt, 1'b1);
    check(clk_oe == 1'b0, "R6", "clk_oe in slave", 48'(clk_oe), 48'd0);
    push(VEC[0]);
    fork
      gen_frames(half, 3, fmt);
      begin
        for (int k = 1; k < 3; k++) push(VEC[k]);
      end
    join
    cap = half - (fmt ? 1 : 0);
    if (cap > SAMPLE_W) cap = SAMPLE_W;
    mask = ~sample_t'((1 << (SAMPLE_W - cap)) - 1);
    check(rx_n == 3, "R6", "slave frames decoded", 48'(rx_n), 48'd3);
    for (int k = 0; k < 3; k++)
      check(rx_l[k] == (VEC[k].left & mask) && rx_r[k] == (VEC[k].right & mask),
            "R7", "slave truncated pair", {rx_l[k], rx_r[k]},
            {VEC[k].left & mask, VEC[k].right & mask});
    check(rx_pad_err == 0 && rx_smax == half, "R6", "slave slots/pad",
          48'(rx_smax), 48'(half));
  endtask

  initial begin
    int starts;
    logic pw;
    // reset state (R10)
    repeat (2) @(posedge clk); #1;
    check(sdata == 1'b0, "R10", "sdata in reset", 48'(sdata), 48'd0);
    check(s_ready == 1'b1, "R10", "s_ready in reset", 48'(s_ready), 48'd1);
    check(clk_oe == 1'b1, "R4", "clk_oe in master", 48'(clk_oe), 48'd1);

    master_run(1'b0, "R3");   // left-justified
    master_run(1'b1, "R2");   // I2S

    slave_run(1'b0, 24);      // 48 Fs, all bits fit (R6)
    slave_run(1'b1, 24);      // I2S loses LSB (R7)
    slave_run(1'b1, 64);      // 128 Fs, padded (R6)

    // R9: acceptance on the same edge as the frame-start load
    do_reset(1'b0, 1'b0);
    starts = 0;
    @(posedge clk); #1; pw = wclk_o;
    while (starts < 2) begin
      @(posedge clk); #1;
      if (wclk_o && !pw) starts++;
      pw = wclk_o;
    end
    check(s_ready == 1'b1, "R9", "ready before collision", 48'(s_ready), 48'd1);
    s_valid = 1'b1; s_left = VEC[2].left; s_right = VEC[2].right;
    @(posedge clk); #1;
    s_valid = 1'b0;
    check(s_ready == 1'b0, "R9", "pair held after collision", 48'(s_ready), 48'd0);
    wait (rx_n >= 3);
    check(rx_l[0] == '0 && rx_r[0] == '0, "R8", "underrun frame silent",
          {rx_l[0], rx_r[0]}, 48'd0);
    check(rx_l[1] == '0 && rx_r[1] == '0, "R9", "colliding frame silent",
          {rx_l[1], rx_r[1]}, 48'd0);
    check(rx_l[2] == VEC[2].left && rx_r[2] == VEC[2].right, "R9", "pair in next frame",
          {rx_l[2], rx_r[2]}, {VEC[2].left, VEC[2].right});

    // R10: asynchronous reset forces data low mid-stream
    do_reset(1'b0, 1'b0);
    push('{left: 24'hFFFFFF, right: 24'hFFFFFF});
    @(posedge clk); #1;
    while (!sdata) begin @(posedge clk); #1; end
    #2 rst_n = 1'b0;
    #1 check(sdata == 1'b0, "R10", "sdata on async reset", 48'(sdata), 48'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_err++;
    $display("FAIL R8 watchdog expired act=%0d exp=%0d", rx_n, NVEC);
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule